// File: doc/BRIEF.md
# Trigger and Event-Number Serial Command Link

This block carries trigger commands from a central timing source to front-end boards over a single serial line. Both ends run on a shared, separately distributed clock, and each clock period carries exactly one bit. A command frame is 38 bits long and holds four fields:

- a start bit, which is always one;
- three trigger-type flags;
- a two-bit action code, which separates a trigger from a TDC counter reset;
- a 32-bit event number.

The transmit half accepts a request together with its fields and shifts the frame onto the line. The line changes only on falling clock edges, so that the receiving flop can sample it on the rising edge half a bit later. The receive half waits on an idle-low line and treats the first one it sees as a start bit. It then collects the remaining 37 bits and presents the decoded fields for one cycle with a valid strobe. Alongside it raises separate strobes for a trigger, for a TDC reset, or for an illegal action code.

A user places the transmit half on the distribution board and the receive half on each front-end board. Inside this block the two halves share one clock domain, so the receiver can also be fed straight from the transmitter.

Top module: `trig_evt_link`

## Requirements
- R1: A frame is 38 bits sent most significant first, in this order: a start bit of 1, then `tx_ttype[2:0]` (bit 2 first), then `tx_cmd[1:0]` (bit 1 first), then `tx_evnum[31:0]` (bit 31 first).
- R2: `ser_out` changes only on falling clock edges. It is 0 after reset and whenever no frame is being sent.
- R3: A rising edge with `tx_req` high and `tx_ready` high accepts a request. The start bit then appears on `ser_out` at the next falling edge, and `tx_ready` is low for the 38 rising edges that follow the accepting edge.
- R4: A request raised while `tx_ready` is low is ignored. The frame in progress is not altered, and no extra frame is sent for that request.
- R5: With `tx_req` held high, consecutive frames are separated by exactly one idle bit of 0. The next start bit appears 39 cycles after the previous one.
- R6: While idle, the receiver treats a 1 sampled on `ser_in` at a rising edge as a start bit. It then samples 37 more bits. After the rising edge that samples the last bit, `rx_valid` is high for exactly one cycle, with `rx_ttype`, `rx_cmd` and `rx_evnum` holding the decoded fields. In loopback, this is the cycle after the 38th rising edge following acceptance.
- R7: During the `rx_valid` cycle, `rx_trig` equals action-code bit 1 (trigger) and `rx_tdc_rst` equals action-code bit 0 (TDC reset). Code 10 therefore gives a trigger only, 11 gives a trigger with a reset, and 01 gives a reset only.
- R8: Action code 00 raises `rx_err` for the `rx_valid` cycle and raises neither `rx_trig` nor `rx_tdc_rst`.
- R9: While `rst_n` is low at a clock edge, the block goes to this state: `tx_ready` = 1, `ser_out` = 0, and all receiver strobes = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both halves |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_req | input | 1 | Request to send a frame |
| tx_ttype | input | 3 | Trigger-type flags to send |
| tx_cmd | input | 2 | Action code to send |
| tx_evnum | input | 32 | Event number to send |
| tx_ready | output | 1 | Transmitter idle, request can be taken |
| ser_out | output | 1 | Serial line, launched on falling edges |
| ser_in | input | 1 | Serial line into the receiver |
| rx_valid | output | 1 | One-cycle strobe: decoded frame present |
| rx_ttype | output | 3 | Received trigger-type flags |
| rx_cmd | output | 2 | Received action code |
| rx_evnum | output | 32 | Received event number |
| rx_trig | output | 1 | One-cycle trigger strobe |
| rx_tdc_rst | output | 1 | One-cycle TDC-reset strobe |
| rx_err | output | 1 | One-cycle illegal-code strobe |

## Verification
The start bit of a request accepted at rising edge A0 is driven at the falling edge after A0. Bit k is valid from that edge onward and is read by the bench 2 ns after rising edge A(k+1), away from both clock edges. `tx_ready` is low from A0 until it rises again at A38. In loopback, the decoded frame and its strobes are due in the cycle after A38, and the bench checks both that cycle and the cycle on either side of it. When a request is held high, the next acceptance falls on A39, its start bit is read after A40, and its decoded frame is due after A77.

// File: rtl/tel_pkg.sv
// Shared widths and types of the trigger/event-number link.
// Assumes one start bit ahead of the body; all widths derive from here.
package tel_pkg;
    localparam int TYPE_W  = 3;
    localparam int CMD_W   = 2;
    localparam int EVT_W   = 32;
    localparam int BODY_W  = TYPE_W + CMD_W + EVT_W;
    localparam int FRAME_W = 1 + BODY_W;

    typedef struct packed {
        logic [TYPE_W-1:0] ttype;
        logic [CMD_W-1:0]  cmd;
        logic [EVT_W-1:0]  evnum;
    } frame_body_t;
endpackage

// File: rtl/tel_cmd_dec.sv
// Action-code decoder: bit 1 requests a trigger, bit 0 requests a TDC
// reset, and an all-zero code is illegal. Purely combinational.
module tel_cmd_dec
    import tel_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output logic             want_trig,
    output logic             want_tdc,
    output logic             illegal
);
    // Map each code bit to its action and flag the empty code.
    always_comb begin
        want_trig = code[CMD_W-1];
        want_tdc  = code[0];
        illegal   = (code == '0);
    end
endmodule

// File: rtl/tel_tx.sv
// Frame transmitter. Loads {1, body} on an accepted request and shifts it
// out MSB first. The line flop launches on the falling edge, so that a
// rising-edge receiver samples mid-bit. Requests made while busy are
// dropped. Assumes clk is the bit clock.
module tel_tx
    import tel_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  frame_body_t body,
    output logic        ready,
    output logic        line
);
    localparam int CNT_W = $clog2(FW + 1);

    logic [FW-1:0]    shreg;
    logic [CNT_W-1:0] left;
    logic             busy;

    // Accept a request when idle; otherwise advance the frame one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            left  <= '0;
            shreg <= '0;
        end else if (!busy) begin
            if (req) begin
                shreg <= {1'b1, body};
                left  <= CNT_W'(FW);
                busy  <= 1'b1;
            end
        end else begin
            shreg <= {shreg[FW-2:0], 1'b0};
            left  <= left - 1'b1;
            if (left == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // Launch the current bit on the falling edge; idle level is zero.
    always_ff @(negedge clk) begin
        if (!rst_n) line <= 1'b0;
        else        line <= busy & shreg[FW-1];
    end

    assign ready = !busy;
endmodule

// File: rtl/tel_rx.sv
// Frame receiver. Samples on the rising edge. A 1 seen while idle opens a
// frame, and the next BODY_W bits are collected. After the last bit it
// registers the fields and pulses valid plus the action strobes for one
// cycle. Assumes the line idles low and frames are separated by idle bits.
module tel_rx
    import tel_pkg::*;
#(
    parameter int BW = BODY_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line,
    output logic        valid,
    output frame_body_t body,
    output logic        trig,
    output logic        tdc_rst,
    output logic        err
);
    localparam int CNT_W = $clog2(BW + 1);

    logic             active;
    logic [CNT_W-1:0] left;
    logic [BW-2:0]    shreg;
    frame_body_t      word;
    logic             d_trig, d_tdc, d_bad;

    assign word = {shreg, line};

    tel_cmd_dec u_dec (
        .code      (word.cmd),
        .want_trig (d_trig),
        .want_tdc  (d_tdc),
        .illegal   (d_bad)
    );

    // Hunt for a start bit, shift in the body, and publish it at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            left    <= '0;
            shreg   <= '0;
            valid   <= 1'b0;
            trig    <= 1'b0;
            tdc_rst <= 1'b0;
            err     <= 1'b0;
            body    <= '0;
        end else begin
            valid   <= 1'b0;
            trig    <= 1'b0;
            tdc_rst <= 1'b0;
            err     <= 1'b0;
            if (!active) begin
                if (line) begin
                    active <= 1'b1;
                    left   <= CNT_W'(BW);
                end
            end else begin
                shreg <= word[BW-2:0];
                left  <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    active  <= 1'b0;
                    valid   <= 1'b1;
                    body    <= word;
                    trig    <= d_trig;
                    tdc_rst <= d_tdc;
                    err     <= d_bad;
                end
            end
        end
    end
endmodule

// File: rtl/trig_evt_link.sv
// Top of the trigger/event-number serial link: a transmitter and a
// receiver on the same bit clock. ser_in may be wired to ser_out of this
// or of another instance. Assumes ser_in is already aligned to clk.
module trig_evt_link
    import tel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic [TYPE_W-1:0] tx_ttype,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic [EVT_W-1:0]  tx_evnum,
    output logic              tx_ready,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              rx_valid,
    output logic [TYPE_W-1:0] rx_ttype,
    output logic [CMD_W-1:0]  rx_cmd,
    output logic [EVT_W-1:0]  rx_evnum,
    output logic              rx_trig,
    output logic              rx_tdc_rst,
    output logic              rx_err
);
    frame_body_t tx_body, rx_body;

    assign tx_body = '{ttype: tx_ttype, cmd: tx_cmd, evnum: tx_evnum};

    tel_tx u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (tx_req),
        .body  (tx_body),
        .ready (tx_ready),
        .line  (ser_out)
    );

    tel_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (ser_in),
        .valid   (rx_valid),
        .body    (rx_body),
        .trig    (rx_trig),
        .tdc_rst (rx_tdc_rst),
        .err     (rx_err)
    );

    assign rx_ttype = rx_body.ttype;
    assign rx_cmd   = rx_body.cmd;
    assign rx_evnum = rx_body.evnum;
endmodule

// File: rtl/tel_link_chk.sv
// Property checker for trig_evt_link, attached through bind below.
module tel_link_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic tx_ready,
    input logic ser_out,
    input logic rx_valid,
    input logic rx_trig,
    input logic rx_tdc_rst,
    input logic rx_err
);
    // Accepting a request makes the transmitter busy.
    assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ready) |=> !tx_ready);

    // An idle transmitter with no accepted request keeps the line low.
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && $past(tx_ready && !tx_req)) |-> !ser_out);

    // When the transmitter frees up, the line is in its idle gap bit.
    assert_gap_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> !ser_out);

    // The valid strobe never lasts two cycles.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // The action strobes appear only together with valid.
    assert_strobe_in_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig || rx_tdc_rst) |-> rx_valid);

    // An illegal code triggers no action.
    assert_err_no_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (rx_valid && !rx_trig && !rx_tdc_rst));
endmodule

bind trig_evt_link tel_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .tx_ready   (tx_ready),
    .ser_out    (ser_out),
    .rx_valid   (rx_valid),
    .rx_trig    (rx_trig),
    .rx_tdc_rst (rx_tdc_rst),
    .rx_err     (rx_err)
);

// File: tb/tb_trig_evt_link.sv
`timescale 1ns/1ps
module tb_trig_evt_link;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_req = 1'b0;
    logic [2:0]  tx_ttype = '0;
    logic [1:0]  tx_cmd = '0;
    logic [31:0] tx_evnum = '0;
    logic        tx_ready, ser_out, ser_in;
    logic        rx_valid, rx_trig, rx_tdc_rst, rx_err;
    logic [2:0]  rx_ttype;
    logic [1:0]  rx_cmd;
    logic [31:0] rx_evnum;

    int vecs = 0;
    int fails = 0;
    int pulses = 0;
    int frames = 0;

    always #4 clk = ~clk;
    assign ser_in = ser_out;

    trig_evt_link dut (.*);

    always @(negedge clk) if (rst_n && rx_valid) pulses++;

    function automatic logic [37:0] frame_of(logic [2:0] t, logic [1:0] c, logic [31:0] e);
        return {1'b1, t, c, e};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [2:0] t, input logic [1:0] c, input logic [31:0] e, input bit poke);
        logic [37:0] got = '0;
        @(negedge clk);
        tx_req = 1'b1; tx_ttype = t; tx_cmd = c; tx_evnum = e;
        @(posedge clk); #2;
        tx_req = 1'b0;
        chk(tx_ready == 1'b0, "R3 ready low after accept", 64'(tx_ready), 64'd0);
        for (int k = 0; k < 38; k++) begin
            @(posedge clk); #2;
            got[37-k] = ser_out;
            if (poke && k == 10) begin
                tx_req = 1'b1; tx_ttype = ~t; tx_cmd = ~c; tx_evnum = ~e;
            end
            if (poke && k == 11) tx_req = 1'b0;
            if (k == 36) chk(rx_valid == 1'b0, "R6 valid not early", 64'(rx_valid), 64'd0);
            if (k < 37 && k > 0) begin
                if (tx_ready) chk(1'b0, "R3 ready low during frame", 64'(tx_ready), 64'd0);
            end
        end
        chk(got == frame_of(t, c, e), "R1 frame bits", 64'(got), 64'(frame_of(t, c, e)));
        chk(tx_ready == 1'b1, "R3 ready back after 38 edges", 64'(tx_ready), 64'd1);
        chk(rx_valid && rx_ttype == t && rx_cmd == c && rx_evnum == e, "R6 decoded fields",
            {rx_valid, 25'd0, rx_ttype, rx_cmd, rx_evnum}, {1'b1, 25'd0, t, c, e});
        chk(rx_trig == c[1] && rx_tdc_rst == c[0], "R7 action strobes",
            64'({rx_trig, rx_tdc_rst}), 64'(c));
        chk(rx_err == (c == 2'b00), "R8 illegal code flag", 64'(rx_err), 64'(c == 2'b00));
        frames++;
        @(posedge clk); #2;
        chk(ser_out == 1'b0, "R2 line idle after frame", 64'(ser_out), 64'd0);
        chk(rx_valid == 1'b0, "R6 valid one cycle", 64'(rx_valid), 64'd0);
    endtask

    task automatic back_to_back(input logic [31:0] e1, input logic [31:0] e2);
        @(negedge clk);
        tx_req = 1'b1; tx_ttype = 3'b101; tx_cmd = 2'b10; tx_evnum = e1;
        @(posedge clk); #2;
        tx_evnum = e2; tx_cmd = 2'b11; tx_ttype = 3'b010;
        for (int k = 1; k <= 38; k++) begin
            @(posedge clk); #2;
        end
        chk(tx_ready == 1'b1, "R5 ready between frames", 64'(tx_ready), 64'd1);
        chk(rx_valid && rx_evnum == e1 && rx_cmd == 2'b10, "R4 first frame unchanged by held request",
            64'(rx_evnum), 64'(e1));
        @(posedge clk); #2;
        chk(tx_ready == 1'b0 && ser_out == 1'b0, "R5 accept after one idle bit",
            64'({tx_ready, ser_out}), 64'd0);
        tx_req = 1'b0;
        @(posedge clk); #2;
        chk(ser_out == 1'b1, "R5 next start bit", 64'(ser_out), 64'd1);
        repeat (37) @(posedge clk);
        #2;
        chk(rx_valid && rx_evnum == e2 && rx_trig && rx_tdc_rst, "R5 second frame decoded",
            64'(rx_evnum), 64'(e2));
        frames += 2;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #2;
        chk(tx_ready == 1'b1 && ser_out == 1'b0 && rx_valid == 1'b0 && rx_trig == 1'b0
            && rx_tdc_rst == 1'b0 && rx_err == 1'b0, "R9 reset state",
            64'({tx_ready, ser_out, rx_valid, rx_trig, rx_tdc_rst, rx_err}), 64'b100000);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(ser_out == 1'b0 && rx_valid == 1'b0, "R2 idle line after reset", 64'(ser_out), 64'd0);

        run_frame(3'b100, 2'b10, 32'h8000_0001, 1'b0);
        run_frame(3'b011, 2'b11, 32'hFFFF_FFFF, 1'b0);
        run_frame(3'b000, 2'b01, 32'h0000_0000, 1'b0);
        run_frame(3'b111, 2'b00, 32'hA5A5_5A5A, 1'b0);
        run_frame(3'b010, 2'b10, 32'h1234_5678, 1'b1);
        repeat (45) @(posedge clk);
        #2;
        chk(pulses == frames, "R4 no frame for busy request", 64'(pulses), 64'(frames));
        back_to_back(32'hDEAD_BEEF, 32'h0BAD_F00D);

        for (int n = 0; n < 30; n++) begin
            logic [2:0] t = 3'($urandom);
            logic [1:0] c = 2'($urandom);
            logic [31:0] e = $urandom;
            run_frame(t, c, e, 1'($urandom));
            repeat ($urandom % 4) @(posedge clk);
        end
        repeat (45) @(posedge clk);
        #2;
        chk(pulses == frames, "R4 valid count matches frames", 64'(pulses), 64'(frames));
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule